// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block is an up-counting timer that serves either as a periodic interval source or as a system watchdog. Software controls it through a single 32-bit control/status word. A write takes effect only when it covers all four bytes and carries the byte 0xA5 in bits 31:24. Any write that is partial or carries a wrong key is dropped whole. This guards the timer against stray stores that could otherwise stop a running watchdog.

An 8-bit counter advances on each count pulse while the timer is enabled. When it wraps, the selected mode decides what happens. In interval mode an interrupt flag is latched, and the interrupt output follows that flag. In watchdog mode a watchdog flag is latched and a one-clock reset request goes out to the system reset controller. Only the power-on reset input clears the register. A reset that the request triggers elsewhere leaves the status visible, so software can find out why the chip restarted.

Top module: `keyed_wdt`

## Requirements
- R1: A write changes the register only when `wr_en` is 1, all four bits of `wr_be` are 1 and `wr_data[31:24]` equals 0xA5. Any other write leaves every control bit and every flag unchanged.
- R2: `rd_data` bit 7 is the enable, bit 6 is the mode (0 interval, 1 watchdog), bit 2 is the interval flag, bit 1 is the watchdog flag and bit 0 is the reset-select bit. Every other bit reads 0, including the key byte, whatever value was written.
- R3: While enable is 1, each clock with `cnt_tick` high adds one to `count`, and the count wraps from 0xFF to 0x00. While enable is 0, `count` holds.
- R4: A wrap in interval mode sets the interval flag at the same edge. `irq` equals that flag.
- R5: A wrap in watchdog mode sets the watchdog flag and drives `rst_req` high for exactly the one clock after the wrap edge.
- R6: A keyed write with 0 in a flag bit clears that flag. A keyed write with 1 in a flag bit leaves that flag unchanged.
- R7: When a wrap sets a flag in the same cycle as a keyed write that clears it, the flag ends up set.
- R8: A keyed write arriving while enable is already 1 leaves the mode bit unchanged. The other bits of that write still take effect.
- R9: With `por_n` low, the register, the count, `irq` and `rst_req` are all 0.
- R10: The reset-select bit stores whatever value a keyed write gives it and reads it back unchanged. It has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data including key byte |
| rd_data | output | 32 | Control/status read value |
| cnt_tick | input | 1 | Count-enable pulse |
| count | output | 8 | Current counter value |
| irq | output | 1 | Interval interrupt, high while interval flag is set |
| rst_req | output | 1 | One-clock watchdog reset request |

## Verification
A counter wrap that sets a flag can land in the same clock as a keyed write that clears that same flag. To provoke this, the bench first leaves the interval flag set. It then ticks the counter to 0xFF and issues the clearing write with the final tick held high in that very cycle. The flag must read back as set afterwards. A second coincidence comes from a mode-changing write while the timer is enabled. For that case the bench confirms that the mode bit holds and that the enable and flag bits of the same write still take effect. A behavioural model compares every output on every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int          CSR_W  = 32;
  localparam logic [7:0]  WR_KEY = 8'hA5;
  localparam int          B_EN   = 7;
  localparam int          B_MODE = 6;
  localparam int          B_IOVF = 2;
  localparam int          B_WOVF = 1;
  localparam int          B_RSEL = 0;
  localparam int          N_FLAG = 2;

  typedef enum logic {MODE_INTERVAL = 1'b0, MODE_WATCHDOG = 1'b1} tmr_mode_e;

  typedef struct packed {
    logic      en;
    tmr_mode_e mode;
    logic      iovf;
    logic      wovf;
    logic      rsel;
  } csr_t;

  function automatic logic [CSR_W-1:0] csr_pack(csr_t c);
    logic [CSR_W-1:0] r;
    r         = '0;
    r[B_EN]   = c.en;
    r[B_MODE] = c.mode;
    r[B_IOVF] = c.iovf;
    r[B_WOVF] = c.wovf;
    r[B_RSEL] = c.rsel;
    return r;
  endfunction

  function automatic logic key_ok(logic [7:0] k);
    return k == WR_KEY;
  endfunction
endpackage

// File: rtl/wdt_write_gate.sv
module wdt_write_gate #(
  parameter int BE_W = 4
) (
  input  logic            wr_en,
  input  logic [BE_W-1:0] wr_be,
  input  logic [7:0]      wr_key,
  output logic            accept
);
  import wdt_pkg::*;
  assign accept = wr_en && (&wr_be) && key_ok(wr_key);
endmodule

// File: rtl/wdt_up_counter.sv
module wdt_up_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         run,
  input  logic         tick,
  output logic [W-1:0] count,
  output logic         wrap
);
  logic step;
  assign step = run && tick;
  assign wrap = step && (&count);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)    count <= '0;
    else if (step) count <= count + 1'b1;
  end

  // R3
  inc_step_chk: assert property (@(posedge clk) disable iff (!por_n)
    step |=> count == W'($past(count) + 1'b1));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    !step |=> $stable(count));
endmodule

// File: rtl/wdt_sticky_flag.sv
module wdt_sticky_flag (
  input  logic clk,
  input  logic por_n,
  input  logic hw_set,
  input  logic sw_clr,
  output logic q
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      q <= 1'b0;
    else if (hw_set) q <= 1'b1;
    else if (sw_clr) q <= 1'b0;
  end

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!por_n)
    hw_set |=> q);
  // R6
  clr_chk: assert property (@(posedge clk) disable iff (!por_n)
    (sw_clr && !hw_set) |=> !q);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int CNT_W = 8,
  parameter int BE_W  = 4
) (
  input  logic                     clk,
  input  logic                     por_n,
  input  logic                     wr_en,
  input  logic [BE_W-1:0]          wr_be,
  input  logic [wdt_pkg::CSR_W-1:0] wr_data,
  output logic [wdt_pkg::CSR_W-1:0] rd_data,
  input  logic                     cnt_tick,
  output logic [CNT_W-1:0]         count,
  output logic                     irq,
  output logic                     rst_req
);
  import wdt_pkg::*;

  localparam int KEY_LSB = CSR_W - 8;

  logic      accept;
  logic      wrap;
  logic      ivl_ovf;
  logic      wd_ovf;
  logic      en_q;
  tmr_mode_e mode_q;
  logic      rsel_q;
  logic      rst_req_q;
  logic [N_FLAG-1:0] flag_set;
  logic [N_FLAG-1:0] flag_clr;
  logic [N_FLAG-1:0] flag_q;
  csr_t      csr;

  wdt_write_gate #(.BE_W(BE_W)) u_gate (
    .wr_en  (wr_en),
    .wr_be  (wr_be),
    .wr_key (wr_data[CSR_W-1:KEY_LSB]),
    .accept (accept)
  );

  wdt_up_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .por_n (por_n),
    .run   (en_q),
    .tick  (cnt_tick),
    .count (count),
    .wrap  (wrap)
  );

  assign ivl_ovf = wrap && (mode_q == MODE_INTERVAL);
  assign wd_ovf  = wrap && (mode_q == MODE_WATCHDOG);

  // index 0: interval flag, index 1: watchdog flag
  assign flag_set = {wd_ovf, ivl_ovf};
  assign flag_clr = {accept && !wr_data[B_WOVF], accept && !wr_data[B_IOVF]};

  for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
    wdt_sticky_flag u_flag (
      .clk    (clk),
      .por_n  (por_n),
      .hw_set (flag_set[i]),
      .sw_clr (flag_clr[i]),
      .q      (flag_q[i])
    );
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      en_q      <= 1'b0;
      mode_q    <= MODE_INTERVAL;
      rsel_q    <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= wd_ovf;
      if (accept) begin
        en_q   <= wr_data[B_EN];
        rsel_q <= wr_data[B_RSEL];
        if (!en_q) mode_q <= tmr_mode_e'(wr_data[B_MODE]);
      end
    end
  end

  assign csr.en   = en_q;
  assign csr.mode = mode_q;
  assign csr.iovf = flag_q[0];
  assign csr.wovf = flag_q[1];
  assign csr.rsel = rsel_q;

  assign rd_data = csr_pack(csr);
  assign irq     = flag_q[0];
  assign rst_req = rst_req_q;

  // R1
  rej_write_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && !accept) |=> ($stable(en_q) && $stable(mode_q) && $stable(rsel_q)));
  // R8
  mode_lock_chk: assert property (@(posedge clk) disable iff (!por_n)
    en_q |=> $stable(mode_q));
  // R5
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
    wd_ovf |=> (rst_req && rd_data[B_WOVF]));
  // R5
  rst_single_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |=> !rst_req);
  // R4
  irq_src_chk: assert property (@(posedge clk) disable iff (!por_n)
    ivl_ovf |=> irq);
endmodule

// File: tb/keyed_wdt_tb.sv
`timescale 1ns/1ps
module keyed_wdt_tb;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = 4'h0;
  logic [31:0] wr_data = 32'h0;
  logic        cnt_tick = 1'b0;
  logic [31:0] rd_data;
  logic [7:0]  count;
  logic        irq;
  logic        rst_req;

  int n_chk = 0;
  int n_fail = 0;
  int rr_seen = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  // behavioural reference state
  bit m_en = 0, m_mode = 0, m_iovf = 0, m_wovf = 0, m_rsel = 0, m_rr = 0;
  int m_cnt = 0;

  always #2 clk = ~clk;

  keyed_wdt u_dut (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .cnt_tick(cnt_tick), .count(count), .irq(irq), .rst_req(rst_req)
  );

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_en <= 0; m_mode <= 0; m_iovf <= 0; m_wovf <= 0; m_rsel <= 0; m_rr <= 0; m_cnt <= 0;
    end else begin
      bit acc, ovf;
      acc = wr_en && (wr_be == 4'hF) && (wr_data[31:24] == 8'hA5);
      ovf = m_en && cnt_tick && (m_cnt == 255);
      if (m_en && cnt_tick) m_cnt <= (m_cnt + 1) % 256;
      m_rr <= ovf && m_mode;
      if (ovf && !m_mode) m_iovf <= 1; else if (acc && !wr_data[2]) m_iovf <= 0;
      if (ovf && m_mode)  m_wovf <= 1; else if (acc && !wr_data[1]) m_wovf <= 0;
      if (acc) begin
        m_en <= wr_data[7];
        m_rsel <= wr_data[0];
        if (!m_en) m_mode <= wr_data[6];
      end
    end
  end

  function automatic logic [31:0] model_rd();
    return {24'h0, m_en, m_mode, 3'b000, m_iovf, m_wovf, m_rsel};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      if (rst_req) rr_seen++;
      check(rd_data == model_rd(), "R2 read word", rd_data, model_rd());
      check(count == 8'(m_cnt), "R3 count", {24'h0, count}, 32'(m_cnt));
      check(irq == m_iovf, "R4 irq", {31'h0, irq}, {31'h0, m_iovf});
      check(rst_req == m_rr, "R5 rst_req", {31'h0, rst_req}, {31'h0, m_rr});
    end
  end

  task automatic step(input bit we, input logic [3:0] be, input logic [31:0] d, input bit tk);
    wr_en = we; wr_be = be; wr_data = d; cnt_tick = tk;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 4'h0; wr_data = 32'h0; cnt_tick = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    started = 1'b1;
    // R9 reset state
    check(rd_data == 32'h0 && count == 8'h0, "R9 reset", rd_data, 32'h0);
    por_n = 1'b1;
    @(negedge clk);

    // R1 partial write and wrong key are dropped
    step(1, 4'h7, 32'hA50000C1, 0);
    check(rd_data == 32'h0, "R1 partial write", rd_data, 32'h0);
    step(1, 4'hF, 32'h5A0000C1, 0);
    check(rd_data == 32'h0, "R1 wrong key", rd_data, 32'h0);

    // R2/R10 keyed write with junk in key echo and reserved bits, flags written 1
    step(1, 4'hF, 32'hA5FFFFFF, 0);
    check(rd_data == 32'h000000C1, "R2 R10 keyed write", rd_data, 32'h000000C1);

    // R5 watchdog wrap with gapped ticks
    rr_seen = 0;
    for (int i = 0; i < 256; i++) begin
      step(0, 4'h0, 32'h0, 1);
      if (i % 3 == 0) step(0, 4'h0, 32'h0, 0);
    end
    step(0, 4'h0, 32'h0, 0);
    check(rr_seen == 1, "R5 one reset pulse", 32'(rr_seen), 32'd1);
    check(rd_data == 32'h000000C3, "R5 watchdog flag", rd_data, 32'h000000C3);

    // R8 mode change while enabled ignored, R6 flag cleared by 0, R10 rsel cleared
    step(1, 4'hF, 32'hA5000080, 0);
    check(rd_data == 32'h000000C0, "R8 R6 R10 mode locked", rd_data, 32'h000000C0);

    // disable, then switch mode to interval
    step(1, 4'hF, 32'hA5000000, 0);
    check(rd_data == 32'h00000040, "R8 disable", rd_data, 32'h00000040);
    begin
      logic [7:0] held;
      held = count;
      step(0, 4'h0, 32'h0, 1);
      step(0, 4'h0, 32'h0, 1);
      check(count == held, "R3 hold when disabled", {24'h0, count}, {24'h0, held});
    end
    step(1, 4'hF, 32'hA5000080, 0);
    check(rd_data == 32'h00000080, "R8 mode change when stopped", rd_data, 32'h00000080);

    // R4 interval wrap
    while (count != 8'hFF) step(0, 4'h0, 32'h0, 1);
    step(0, 4'h0, 32'h0, 1);
    check(rd_data == 32'h00000084 && irq, "R4 interval flag", rd_data, 32'h00000084);

    // R6 writing 1 keeps the flag
    step(1, 4'hF, 32'hA5000084, 0);
    check(rd_data == 32'h00000084, "R6 write one keeps", rd_data, 32'h00000084);

    // R7 clear coincides with a new wrap
    while (count != 8'hFF) step(0, 4'h0, 32'h0, 1);
    step(1, 4'hF, 32'hA5000080, 1);
    check(rd_data == 32'h00000084 && count == 8'h00, "R7 set wins", rd_data, 32'h00000084);

    // R6 plain clear
    step(1, 4'hF, 32'hA5000080, 0);
    check(rd_data == 32'h00000080 && !irq, "R6 clear", rd_data, 32'h00000080);

    // R9 power-on reset mid-run
    repeat (5) step(0, 4'h0, 32'h0, 1);
    por_n = 1'b0;
    @(negedge clk);
    check(rd_data == 32'h0 && count == 8'h0 && !irq && !rst_req, "R9 por mid-run", rd_data, 32'h0);
    por_n = 1'b1;
    step(0, 4'h0, 32'h0, 1);
    check(count == 8'h0, "R9 stays stopped", {24'h0, count}, 32'h0);
    finish_run();
  end
endmodule